// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one per clock. A controller pulses a start strobe together with the first column, a length code and an order bit. The block captures the mode at that moment and steps through the burst in either sequential-wrap order or XOR (interleaved) order. Every address comes with a valid flag, and the final address of a finite burst also carries a last flag.

A full-page burst walks every column of the row in sequential order. It wraps at the row end and runs until it is stopped. A stop input cuts any burst short. A new start strobe replaces a burst that is still running.

When a burst ends, whether it completes, is stopped or is replaced, a single-cycle done pulse follows. The controller can use this pulse to launch a self-timed precharge. Bank and row selection, data movement and DRAM timing are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: When start_i is high at a rising edge, valid_o is high in the following cycle and col_o equals the start_col_i that was sampled. Each later cycle presents the next step of the burst.
- R2: Length code on bl_code_i: 0 gives 1 location, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set gives a full page. The length code and bt_i are sampled only together with start_i, so later changes do not affect the running burst.
- R3: Sequential order (bt_i = 0). Step i keeps the column bits above log2(length) from the start column. Its low log2(length) bits equal (start low bits + i) modulo the length.
- R4: Interleaved order (bt_i = 1). Step i equals the start column with its low log2(length) bits XORed with i.
- R5: A length of 1 presents only the start column, for one cycle, with valid_o and last_o both high in that cycle.
- R6: last_o is high exactly with the final address of a finite burst. valid_o is low in the cycle after that address unless a new start was taken.
- R7: A full-page burst steps sequentially through all 2^COL_W columns, wrapping from the top column to 0. It ignores bt_i, never raises last_o and runs until a stop.
- R8: If stop_i is high in a cycle where valid_o is high, the address shown in that cycle stands and valid_o is low from the next cycle on. A stop while no burst runs has no effect.
- R9: done_o pulses high for exactly one cycle in the cycle after a burst ends, whether by its last address, by stop_i or by being replaced by a new start. When stop_i falls on the last address, only one pulse occurs.
- R10: start_i while a burst runs begins the new burst in the next cycle from the new start column. start_i takes priority over a simultaneous stop_i.
- R11: While rst_n is low, and in the first cycle after it is released, valid_o, last_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | First column of the burst |
| bl_code_i | input | 3 | Burst length code (see R2) |
| bt_i | input | 1 | Order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o holds a burst address |
| last_o | output | 1 | col_o is the final address of a finite burst |
| done_o | output | 1 | One-cycle pulse after a burst ends |

## Verification
Two functions can fall on the same cycle here. Natural completion can coincide with a stop, and a completing or stopped burst can coincide with a new start. The bench drives stop_i during the cycle that shows last_o and expects exactly one done pulse. It also drives start_i and stop_i together in the middle of a burst and expects the new burst's first column, still valid, while done_o reports the end of the old one. Both orders are checked against hand-computed column tables for every finite length, with the mode inputs scrambled after each start.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int BC_CODE_W = 3;

    typedef enum logic {
        BC_ORD_SEQ = 1'b0,
        BC_ORD_XOR = 1'b1
    } bc_order_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [burst_col_pkg::BC_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]                    mask_o,
    output logic                                full_o
);
    localparam int CODE_W = burst_col_pkg::BC_CODE_W;

    // Bit CODE_W-1 selects full page; the low bits give log2(length).
    always_comb begin
        full_o = code_i[CODE_W-1];
        mask_o = '0;
        if (full_o) begin
            mask_o = '1;
        end else begin
            for (int b = 0; b < COL_W; b++) begin
                mask_o[b] = (b < int'(code_i[CODE_W-2:0]));
            end
        end
    end
endmodule

// File: rtl/burst_addr_order.sv
module burst_addr_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0]              base_i,
    input  logic [COL_W-1:0]              step_i,
    input  logic [COL_W-1:0]              mask_i,
    input  burst_col_pkg::bc_order_e      order_i,
    output logic [COL_W-1:0]              col_o
);
    import burst_col_pkg::*;

    logic [COL_W-1:0] sum_w;
    logic [COL_W-1:0] seq_col_w;
    logic [COL_W-1:0] xor_col_w;

    always_comb begin
        sum_w     = base_i + step_i;
        seq_col_w = (base_i & ~mask_i) | (sum_w & mask_i);
        xor_col_w = base_i ^ (step_i & mask_i);
        col_o     = (order_i == BC_ORD_XOR) ? xor_col_w : seq_col_w;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [COL_W-1:0]                    start_col_i,
    input  logic [burst_col_pkg::BC_CODE_W-1:0] bl_code_i,
    input  logic                                bt_i,
    input  logic                                stop_i,
    output logic [COL_W-1:0]                    col_o,
    output logic                                valid_o,
    output logic                                last_o,
    output logic                                done_o
);
    import burst_col_pkg::*;

    localparam logic [COL_W-1:0] STEP_ONE = COL_W'(1);

    typedef struct packed {
        logic             active;
        logic             last;
        logic             done;
        logic             full;
        bc_order_e        order;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] step;
    } gen_state_t;

    gen_state_t s_d, s_q;

    logic [COL_W-1:0] dec_mask_w;
    logic             dec_full_w;
    logic [COL_W-1:0] step_inc_w;
    logic [COL_W-1:0] sel_base_w;
    logic [COL_W-1:0] sel_step_w;
    logic [COL_W-1:0] sel_mask_w;
    bc_order_e        sel_order_w;
    bc_order_e        new_order_w;
    logic [COL_W-1:0] nxt_col_w;

    burst_len_decode #(.COL_W(COL_W)) u_len_decode (
        .code_i (bl_code_i),
        .mask_o (dec_mask_w),
        .full_o (dec_full_w)
    );

    // One address unit serves both the first step of a new burst and the
    // next step of the running one.
    always_comb begin
        step_inc_w  = s_q.step + STEP_ONE;
        new_order_w = dec_full_w ? BC_ORD_SEQ : bc_order_e'(bt_i);
        sel_base_w  = start_i ? start_col_i : s_q.base;
        sel_step_w  = start_i ? '0          : step_inc_w;
        sel_mask_w  = start_i ? dec_mask_w  : s_q.mask;
        sel_order_w = start_i ? new_order_w : s_q.order;
    end

    burst_addr_order #(.COL_W(COL_W)) u_addr_order (
        .base_i  (sel_base_w),
        .step_i  (sel_step_w),
        .mask_i  (sel_mask_w),
        .order_i (sel_order_w),
        .col_o   (nxt_col_w)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = s_q.active && (s_q.last || stop_i || start_i);
        if (start_i) begin
            s_d.active = 1'b1;
            s_d.base   = start_col_i;
            s_d.mask   = dec_mask_w;
            s_d.full   = dec_full_w;
            s_d.order  = new_order_w;
            s_d.step   = '0;
            s_d.col    = nxt_col_w;
            s_d.last   = !dec_full_w && (dec_mask_w == '0);
        end else if (s_q.active) begin
            if (stop_i || s_q.last) begin
                s_d.active = 1'b0;
                s_d.last   = 1'b0;
            end else begin
                s_d.step = step_inc_w;
                s_d.col  = nxt_col_w;
                s_d.last = !s_q.full && (step_inc_w == s_q.mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign col_o   = s_q.col;
    assign valid_o = s_q.active;
    assign last_o  = s_q.last;
    assign done_o  = s_q.done;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             done_o
);
    a_r1_start_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    a_r1_start_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_o == $past(start_col_i)));

    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r6_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    a_r9_done_follows_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_o));

    a_r9_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (last_o || stop_i)) |=> done_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .done_o      (done_o)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

    localparam int COL_W = 8;

    typedef struct packed {
        logic [7:0]  col;
        logic [2:0]  code;
        logic        bt;
        logic [3:0]  len;
        logic [63:0] exp;   // step i in bits [8*i +: 8]
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h05, 3'd3, 1'b0, 4'd8, 64'h0403020100070605},
        '{8'h05, 3'd3, 1'b1, 4'd8, 64'h0203000106070405},
        '{8'h2F, 3'd2, 1'b0, 4'd4, 64'h000000002E2D2C2F},
        '{8'h2F, 3'd2, 1'b1, 4'd4, 64'h000000002C2D2E2F},
        '{8'h9B, 3'd1, 1'b0, 4'd2, 64'h0000000000009A9B},
        '{8'h9A, 3'd1, 1'b1, 4'd2, 64'h0000000000009B9A},
        '{8'h73, 3'd0, 1'b1, 4'd1, 64'h0000000000000073},
        '{8'hC6, 3'd3, 1'b0, 4'd8, 64'hC5C4C3C2C1C0C7C6},
        '{8'hC6, 3'd3, 1'b1, 4'd8, 64'hC1C0C3C2C5C4C7C6}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       bl_code_i = '0;
    logic             bt_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl_code_i   (bl_code_i),
        .bt_i        (bt_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .done_o      (done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge showing step 0.
    // Mode inputs are scrambled afterwards (R2 sampling).
    task automatic start_burst(input logic [7:0] col, input logic [2:0] code, input logic bt);
        start_i     = 1'b1;
        start_col_i = col;
        bl_code_i   = code;
        bt_i        = bt;
        @(negedge clk);
        start_i     = 1'b0;
        start_col_i = ~col;
        bl_code_i   = 3'd6;
        bt_i        = ~bt;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 valid in reset", 32'(valid_o), 32'd0);
        chk("R11 last in reset", 32'(last_o), 32'd0);
        chk("R11 done in reset", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid after reset", 32'(valid_o), 32'd0);
        chk("R11 done after reset", 32'(done_o), 32'd0);

        // Table walk: R1 R2 R3 R4 R5 R6 R9
        foreach (VECS[v]) begin
            start_burst(VECS[v].col, VECS[v].code, VECS[v].bt);
            for (int i = 0; i < int'(VECS[v].len); i++) begin
                if (i > 0) @(negedge clk);
                chk("R1 valid", 32'(valid_o), 32'd1);
                chk(VECS[v].bt ? "R4 interleaved col" : "R3 sequential col",
                    32'(col_o), 32'(VECS[v].exp[8*i +: 8]));
                chk(VECS[v].len == 4'd1 ? "R5 single last" : "R6 last flag",
                    32'(last_o), 32'(i == int'(VECS[v].len) - 1));
            end
            @(negedge clk);
            chk("R6 valid drops after last", 32'(valid_o), 32'd0);
            chk("R9 done after last", 32'(done_o), 32'd1);
            @(negedge clk);
            chk("R9 done single cycle", 32'(done_o), 32'd0);
        end

        // R7 full page with wrap, bt ignored, then stop (R8)
        start_burst(8'hFC, 3'd7, 1'b1);
        for (int i = 0; i < 260; i++) begin
            if (i > 0) @(negedge clk);
            chk("R7 full page col", 32'(col_o), 32'((8'hFC + i) & 8'hFF));
            chk("R7 full page no last", 32'(last_o), 32'd0);
        end
        chk("R7 still valid", 32'(valid_o), 32'd1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 stop ends full page", 32'(valid_o), 32'd0);
        chk("R9 done after stop", 32'(done_o), 32'd1);
        @(negedge clk);
        chk("R9 done clears", 32'(done_o), 32'd0);

        // R2 reserved code with bit 2 set acts as full page, R7 ignores bt
        start_burst(8'hF0, 3'd5, 1'b1);
        chk("R2 code5 step0", 32'(col_o), 32'hF0);
        @(negedge clk);
        chk("R2 code5 step1", 32'(col_o), 32'hF1);
        @(negedge clk);
        chk("R7 code5 step2 sequential", 32'(col_o), 32'hF2);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 stop code5", 32'(valid_o), 32'd0);
        @(negedge clk);

        // R8 stop mid 8-burst
        start_burst(8'h05, 3'd3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 col in stop cycle", 32'(col_o), 32'h07);
        chk("R8 valid in stop cycle", 32'(valid_o), 32'd1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 valid after stop", 32'(valid_o), 32'd0);
        chk("R9 done after mid stop", 32'(done_o), 32'd1);
        @(negedge clk);
        chk("R8 stays idle", 32'(valid_o), 32'd0);
        chk("R9 done one cycle", 32'(done_o), 32'd0);

        // R9 stop coinciding with last
        start_burst(8'h2F, 3'd2, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6 last before coincident stop", 32'(last_o), 32'd1);
        chk("R3 col at coincident stop", 32'(col_o), 32'h2E);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9 done on stop+last", 32'(done_o), 32'd1);
        chk("R8 valid on stop+last", 32'(valid_o), 32'd0);
        @(negedge clk);
        chk("R9 single pulse on stop+last", 32'(done_o), 32'd0);

        // R8 stop while idle is ignored
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 idle stop valid", 32'(valid_o), 32'd0);
        chk("R8 idle stop done", 32'(done_o), 32'd0);
        @(negedge clk);
        chk("R8 idle stop done later", 32'(done_o), 32'd0);

        // R10 start with stop during a running burst
        start_burst(8'h05, 3'd3, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 col before restart", 32'(col_o), 32'h00);
        start_i     = 1'b1;
        start_col_i = 8'h2F;
        bl_code_i   = 3'd2;
        bt_i        = 1'b1;
        stop_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        bt_i    = 1'b0;
        chk("R10 restart valid", 32'(valid_o), 32'd1);
        chk("R10 restart col", 32'(col_o), 32'h2F);
        chk("R9 done on replace", 32'(done_o), 32'd1);
        @(negedge clk);
        chk("R10 new burst step1", 32'(col_o), 32'h2E);
        chk("R9 done clears after replace", 32'(done_o), 32'd0);
        @(negedge clk);
        chk("R10 new burst step2", 32'(col_o), 32'h2D);
        @(negedge clk);
        chk("R10 new burst step3", 32'(col_o), 32'h2C);
        chk("R6 new burst last", 32'(last_o), 32'd1);
        @(negedge clk);
        chk("R6 new burst ends", 32'(valid_o), 32'd0);
        chk("R9 new burst done", 32'(done_o), 32'd1);
        @(negedge clk);

        finish_run();
    end
endmodule